// File: doc/BRIEF.md
# Sub-word Memory Lane Access Unit

This block is the front end of a data memory that is organised as fixed-width rows. A requester gives a byte address, an access size of 1, 2, 4 or 8 bytes, a load/store flag, a byte-swap flag and write data. The unit splits the address into a row index and a byte offset inside the row. A load returns the addressed lane of the row, shifted down so that it starts at bit 0. A store merges the lane into the row with a read-modify-write. A store that covers the whole row overwrites the row.

The swap flag reverses the byte order over the access width. On a load the reversal follows the lane extraction. On a store it comes before the merge. An access whose offset is not a multiple of its size is rejected with an error response and does not change the memory. Rows that have not been written since reset read as zero. The unit accepts one request per cycle and answers each request exactly one cycle later.

Top module: `lane_access_unit`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high on the following cycle. `rsp_valid` is low after reset and in every cycle that does not follow a request.
- R2: The row index is the byte address shifted right by log2(ROW_BYTES). The byte offset is the address modulo ROW_BYTES.
- R3: `req_size` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. A request is rejected when its offset is not a multiple of the size, or when the size exceeds the row. A rejected request gives `rsp_misalign`=1 and `rsp_rdata`=0, and it leaves memory unchanged.
- R4: A load returns the addressed bytes right-aligned and zero-extended. Byte k of a row is bits 8k+7:8k, so a lane at offset o occupies bits starting at 8o.
- R5: A store narrower than the row changes only the bytes of its lane. All other bytes of the row keep their previous contents.
- R6: A store as wide as the row replaces the whole row with the write data.
- R7: A row that has not been written since reset reads as zero.
- R8: With `req_swap`=1, a load returns the extracted lane with its bytes reversed over the access width.
- R9: A store takes only the low size bytes of `req_wdata`. With `req_swap`=1 those bytes are reversed before the merge.
- R10: A store that is not rejected answers with `rsp_misalign`=0 and `rsp_rdata`=0.
- R11: Requests may arrive on consecutive cycles. A load sees the effect of a store issued in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address (log2(ROWS*ROW_BYTES) bits) |
| req_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_store | input | 1 | 1 = store, 0 = load |
| req_swap | input | 1 | Reverse byte order over the access width |
| req_wdata | input | ROW_BYTES*8 | Store data, right-aligned |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | ROW_BYTES*8 | Load data, right-aligned and zero-extended |
| rsp_misalign | output | 1 | Request was rejected |

## Verification
The bench builds the unit with ROW_BYTES=8 and ROWS=8, which gives a 6-bit address. With 8-byte rows every size code is legal in width, so each size can be exercised at every offset, both aligned and misaligned. The small row count lets directed tests reach the highest row index, and it makes random traffic return often enough to the same rows that read-modify-write merges land on rows that already hold data. The swap and misalignment paths are crossed with all four sizes.

// File: rtl/lane_pkg.sv
// Package: shared constants and helpers for the lane access unit.
// Assumes access sizes are powers of two up to 8 bytes.
package lane_pkg;

    localparam int MAX_LOG_BYTES = 3;
    localparam int SIZE_W        = 2;
    localparam int NB_W          = MAX_LOG_BYTES + 1;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // Convert a size code into a byte count.
    function automatic logic [NB_W-1:0] size_to_bytes(input logic [SIZE_W-1:0] code);
        return NB_W'(1) << code;
    endfunction

endpackage

// File: rtl/lane_decode.sv
// Module: lane_decode
// Splits a byte address into a row index and a byte offset, turns the size
// code into a byte count and flags rejected requests (misaligned, or wider
// than a row). Purely combinational.
// Assumes ROW_BYTES and ROWS are powers of two, ROW_BYTES >= 2.
module lane_decode
    import lane_pkg::*;
#(
    parameter  int ROW_BYTES = 8,
    parameter  int ROWS      = 16,
    localparam int OFF_W     = $clog2(ROW_BYTES),
    localparam int IDX_W     = $clog2(ROWS),
    localparam int ADDR_W    = OFF_W + IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off,
    output logic [NB_W-1:0]   nbytes,
    output logic              full,
    output logic              reject
);

    localparam int CW = (OFF_W > NB_W) ? OFF_W : NB_W;

    logic [CW-1:0] off_c;
    logic [CW-1:0] low_mask;
    logic          too_wide;

    // Field split of the address.
    assign off    = addr[OFF_W-1:0];
    assign idx    = addr[ADDR_W-1:OFF_W];

    // Byte count and width classification.
    assign nbytes   = size_to_bytes(size);
    assign full     = (int'(nbytes) == ROW_BYTES);
    assign too_wide = (int'(nbytes) > ROW_BYTES);

    // Offset must be a multiple of the size.
    assign off_c    = CW'(off);
    assign low_mask = CW'(nbytes - NB_W'(1));
    assign reject   = too_wide || ((off_c & low_mask) != '0);

endmodule

// File: rtl/lane_swap.sv
// Module: lane_swap
// Reverses the order of the low nbytes bytes of a row-wide value when
// enabled. Bytes above the access width come out as zero while reversing.
// When disabled the value passes through unchanged.
module lane_swap
    import lane_pkg::*;
#(
    parameter  int ROW_BYTES = 8,
    localparam int ROW_W     = ROW_BYTES * 8
) (
    input  logic [ROW_W-1:0] din,
    input  logic [NB_W-1:0]  nbytes,
    input  logic             en,
    output logic [ROW_W-1:0] dout
);

    int nb;

    // Clamp the count to the row so every index stays in range.
    always_comb begin
        nb = (int'(nbytes) > ROW_BYTES) ? ROW_BYTES : int'(nbytes);
    end

    // Mirror the active bytes around the centre of the access.
    always_comb begin
        dout = din;
        if (en) begin
            dout = '0;
            for (int i = 0; i < ROW_BYTES; i++) begin
                if (i < nb) begin
                    dout[8*i +: 8] = din[8*(nb-1-i) +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/lane_shifter.sv
// Module: lane_shifter
// Builds the lane mask for an access, extracts the lane from a row for
// loads and merges store data into the row for stores. Purely combinational.
// Assumes the request has already been checked for alignment.
module lane_shifter
    import lane_pkg::*;
#(
    parameter  int ROW_BYTES = 8,
    localparam int ROW_W     = ROW_BYTES * 8,
    localparam int OFF_W     = $clog2(ROW_BYTES)
) (
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] data_in,
    input  logic [OFF_W-1:0] off,
    input  logic [NB_W-1:0]  nbytes,
    input  logic             full,
    output logic [ROW_W-1:0] lane_out,
    output logic [ROW_W-1:0] merged_out
);

    logic [ROW_W-1:0] mask;
    logic [ROW_W-1:0] mask_sh;
    int               shamt;

    // Right-aligned mask covering nbytes bytes.
    always_comb begin
        mask = '0;
        for (int b = 0; b < ROW_BYTES; b++) begin
            if (b < int'(nbytes)) begin
                mask[8*b +: 8] = 8'hFF;
            end
        end
    end

    // Lane position inside the row.
    always_comb begin
        shamt   = int'(off) * 8;
        mask_sh = mask << shamt;
    end

    // Load path: isolate the lane, then move it down to bit 0.
    always_comb begin
        lane_out = (row_in & mask_sh) >> shamt;
    end

    // Store path: whole-row replace, or clear the lane and insert the data.
    always_comb begin
        if (full) begin
            merged_out = data_in;
        end else begin
            merged_out = (row_in & ~mask_sh) | ((data_in & mask) << shamt);
        end
    end

endmodule

// File: rtl/lane_rowfile.sv
// Module: lane_rowfile
// Row storage with one asynchronous read port and one synchronous write
// port. Each row carries a written flag that reset clears. A row whose flag
// is clear reads as zero, so the array itself needs no reset.
module lane_rowfile #(
    parameter  int ROW_BYTES = 8,
    parameter  int ROWS      = 16,
    localparam int ROW_W     = ROW_BYTES * 8,
    localparam int IDX_W     = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [ROW_W-1:0] rd_row,
    input  logic             we,
    input  logic [ROW_W-1:0] wr_row
);

    logic [ROW_W-1:0] rows [ROWS];
    logic [ROWS-1:0]  written;

    // Per-row written flags, set on first write and cleared by reset.
    for (genvar r = 0; r < ROWS; r++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                written[r] <= 1'b0;
            end else if (we && (idx == IDX_W'(r))) begin
                written[r] <= 1'b1;
            end
        end
    end

    // Row array write.
    always_ff @(posedge clk) begin
        if (we) begin
            rows[idx] <= wr_row;
        end
    end

    // Read with zero substitution for rows not yet written.
    always_comb begin
        rd_row = written[idx] ? rows[idx] : '0;
    end

    // R7: after a write, the written row reads back exactly what was stored.
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rows[$past(idx)] == $past(wr_row)) && written[$past(idx)]);

endmodule

// File: rtl/lane_access_unit.sv
// Module: lane_access_unit
// Byte-addressed load/store front end for a row-organised memory. It
// accepts one request per cycle and answers one cycle later. Loads extract
// a lane, stores do a read-modify-write within one row, optional byte
// reversal is applied over the access width, and misaligned requests are
// rejected without a write.
// Assumes ROW_BYTES and ROWS are powers of two and ROW_BYTES >= 2.
module lane_access_unit
    import lane_pkg::*;
#(
    parameter  int ROW_BYTES = 8,
    parameter  int ROWS      = 16,
    localparam int ROW_W     = ROW_BYTES * 8,
    localparam int OFF_W     = $clog2(ROW_BYTES),
    localparam int IDX_W     = $clog2(ROWS),
    localparam int ADDR_W    = OFF_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_store,
    input  logic              req_swap,
    input  logic [ROW_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [ROW_W-1:0]  rsp_rdata,
    output logic              rsp_misalign
);

    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] off;
    logic [NB_W-1:0]  nbytes;
    logic             full;
    logic             reject;
    logic [ROW_W-1:0] old_row;
    logic [ROW_W-1:0] store_data;
    logic [ROW_W-1:0] lane_raw;
    logic [ROW_W-1:0] lane_final;
    logic [ROW_W-1:0] new_row;
    logic             row_we;

    lane_decode #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_decode (
        .addr   (req_addr),
        .size   (req_size),
        .idx    (idx),
        .off    (off),
        .nbytes (nbytes),
        .full   (full),
        .reject (reject)
    );

    lane_rowfile #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_rows (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (idx),
        .rd_row (old_row),
        .we     (row_we),
        .wr_row (new_row)
    );

    // Store data is reversed before the merge.
    lane_swap #(.ROW_BYTES(ROW_BYTES)) u_swap_st (
        .din    (req_wdata),
        .nbytes (nbytes),
        .en     (req_swap),
        .dout   (store_data)
    );

    lane_shifter #(.ROW_BYTES(ROW_BYTES)) u_shift (
        .row_in     (old_row),
        .data_in    (store_data),
        .off        (off),
        .nbytes     (nbytes),
        .full       (full),
        .lane_out   (lane_raw),
        .merged_out (new_row)
    );

    // Load data is reversed after the extraction.
    lane_swap #(.ROW_BYTES(ROW_BYTES)) u_swap_ld (
        .din    (lane_raw),
        .nbytes (nbytes),
        .en     (req_swap),
        .dout   (lane_final)
    );

    // Write only for accepted stores.
    assign row_we = req_valid && req_store && !reject;

    // Response register: one-cycle answer to every request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_misalign <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_misalign <= req_valid && reject;
            if (req_valid && !req_store && !reject) begin
                rsp_rdata <= lane_final;
            end else begin
                rsp_rdata <= '0;
            end
        end
    end

    // Byte enables of the addressed lane, for the merge check below.
    logic [ROW_W-1:0] keep_mask;
    for (genvar b = 0; b < ROW_BYTES; b++) begin : g_keep
        assign keep_mask[8*b +: 8] =
            ((b >= int'(off)) && (b < int'(off) + int'(nbytes))) ? 8'h00 : 8'hFF;
    end

    // R1: every request is answered on the next cycle.
    a_r1_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1: no response without a request.
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: a rejected request is flagged, returns zero and writes nothing.
    a_r3_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && reject) |=> (rsp_misalign && (rsp_rdata == '0)));

    a_r3_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && reject) |=> $stable(old_row) || (idx != $past(idx)));

    // R5: bytes outside the lane are carried through the merge unchanged.
    a_r5_keep_outside: assert property (@(posedge clk) disable iff (!rst_n)
        row_we |-> (((new_row ^ old_row) & keep_mask) == '0));

    // R4: load data above the access width is zero.
    a_r4_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_misalign && (int'($past(nbytes)) < ROW_BYTES))
        |-> ((rsp_rdata >> (8 * int'($past(nbytes)))) == '0));

endmodule

// File: tb/lane_access_unit_test.sv
// Scoreboard bench: the driver computes expected responses from a row
// model and queues them; a monitor compares every response in order.
module lane_access_unit_test;

    localparam int RB   = 8;
    localparam int NR   = 8;
    localparam int AW   = 6;

    typedef struct {
        logic        err;
        logic [63:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_store = 1'b0;
    logic        req_swap = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_misalign;

    int errors = 0;
    int checks = 0;
    exp_t q[$];
    logic [63:0] model [NR];

    always #5 clk = ~clk;

    lane_access_unit #(.ROW_BYTES(RB), .ROWS(NR)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_store    (req_store),
        .req_swap     (req_swap),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .rsp_misalign (rsp_misalign)
    );

    function automatic logic [63:0] lane_mask(input int w);
        logic [63:0] m = '0;
        for (int i = 0; i < w; i++) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [63:0] rev(input logic [63:0] v, input int w);
        logic [63:0] r = '0;
        for (int i = 0; i < w; i++) r[8*i +: 8] = v[8*(w-1-i) +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Driver: present one request and queue its expected response.
    task automatic issue(input logic [AW-1:0] a, input logic [1:0] sz,
                         input logic st, input logic sw,
                         input logic [63:0] wd, input string tag);
        exp_t e;
        int w, off, idx;
        logic [63:0] m, row, d;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz;
        req_store = st; req_swap = sw; req_wdata = wd;
        w = 1 << sz; off = int'(a) % RB; idx = int'(a) / RB;
        m = lane_mask(w);
        e.tag = tag; e.err = (off % w) != 0; e.data = '0;
        if (!e.err) begin
            row = model[idx];
            if (st) begin
                d = wd & m;
                if (sw) d = rev(d, w);
                model[idx] = (row & ~(m << (off*8))) | (d << (off*8));
            end else begin
                d = (row >> (off*8)) & m;
                if (sw) d = rev(d, w);
                e.data = d;
            end
        end
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response with the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1 unexpected response", 64'(rsp_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rsp_misalign == e.err, {e.tag, " err"},
                          64'(rsp_misalign), 64'(e.err));
                    check(rsp_rdata == e.data, {e.tag, " data"},
                          rsp_rdata, e.data);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 reset valid", 64'(rsp_valid), 64'd0);
        check(rsp_rdata == '0, "R1 reset data", rsp_rdata, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 idle after reset", 64'(rsp_valid), 64'd0);

        // Unwritten rows read as zero.
        issue(6'h10, 2'd3, 1'b0, 1'b0, 64'd0, "R7 unwritten row");
        // Full-row store, then an immediate load.
        issue(6'h08, 2'd3, 1'b1, 1'b0, 64'h1122334455667788, "R6/R10 full store");
        issue(6'h08, 2'd3, 1'b0, 1'b0, 64'd0, "R11 load after store");
        // Sub-word extraction at various offsets.
        issue(6'h09, 2'd0, 1'b0, 1'b0, 64'd0, "R4 byte at offset 1");
        issue(6'h0A, 2'd1, 1'b0, 1'b0, 64'd0, "R4 half at offset 2");
        issue(6'h0C, 2'd2, 1'b0, 1'b0, 64'd0, "R2/R4 word at offset 4");
        // Byte store with upper garbage in the data.
        issue(6'h0B, 2'd0, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFAB, "R9/R10 byte store");
        issue(6'h08, 2'd3, 1'b0, 1'b0, 64'd0, "R5 merge preserved row");
        // Misaligned accesses rejected, memory unchanged.
        issue(6'h0B, 2'd1, 1'b0, 1'b0, 64'd0, "R3 misaligned load");
        issue(6'h0A, 2'd2, 1'b1, 1'b0, 64'hDEADBEEF, "R3 misaligned store");
        issue(6'h0E, 2'd3, 1'b1, 1'b0, 64'h5555, "R3 misaligned dword store");
        issue(6'h08, 2'd3, 1'b0, 1'b0, 64'd0, "R3 row unchanged");
        // Byte reversal on store and load.
        issue(6'h12, 2'd1, 1'b1, 1'b1, 64'h1234, "R9 swapped half store");
        issue(6'h10, 2'd3, 1'b0, 1'b0, 64'd0, "R9/R7 row after swapped store");
        issue(6'h12, 2'd1, 1'b0, 1'b1, 64'd0, "R8 swapped half load");
        issue(6'h08, 2'd3, 1'b0, 1'b1, 64'd0, "R8 swapped full load");
        issue(6'h0C, 2'd2, 1'b0, 1'b1, 64'd0, "R8 swapped word load");
        // Highest row index.
        issue(6'h3C, 2'd2, 1'b1, 1'b0, 64'hCAFEF00D, "R2 top row word store");
        issue(6'h38, 2'd3, 1'b0, 1'b0, 64'd0, "R2 top row load");
        issue(6'h3F, 2'd0, 1'b0, 1'b0, 64'd0, "R2/R4 last byte");
        idle();
        idle();

        // Mixed traffic, mostly aligned, back to back.
        for (int i = 0; i < 120; i++) begin
            logic [1:0] sz;
            logic [AW-1:0] a;
            sz = 2'($urandom_range(0, 3));
            a  = AW'($urandom_range(0, 63));
            if ($urandom_range(0, 3) != 0) a = a & ~AW'((1 << sz) - 1);
            issue(a, sz, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  {$urandom, $urandom}, "R11 mixed traffic R5 R8 R9");
        end
        idle();
        idle();
        idle();
        check(q.size() == 0, "R1 all answered", 64'(q.size()), 64'd0);
        summary();
        $finish;
    end

endmodule